// File: doc/BRIEF.md
# Quadrature Position Counter with Index Zeroing

This block turns the two phase lines of an incremental encoder into a signed position count. It counts on every edge of either phase, so one full quadrature cycle moves the count by four. The direction of each step comes from the order in which the two phases change. The phase lines and the index line are asynchronous to the block clock, so each passes through its own synchroniser chain before any decoding.

When the index-enable input is high, a rising edge on the index line loads the count with zero. In the same clock edge the block checks the count it held just before the clear. An encoder that lost no edges reaches the index with a count within three steps of zero. If the old value falls outside that window, the lost-count flag goes high. The flag keeps its value until the next index event, which sets it or clears it again.

Top module: `quadIndexCounter`

## Requirements
- R1: While reset is high, and on the first cycle after reset, `position` is 0 and `lostCount` is 0.
- R2: A forward step increments `position` by one. A forward step is a change of the phase pair (A,B) along the order (0,0)->(1,0)->(1,1)->(0,1)->(0,0). The new count is visible after the third rising clock edge that follows the input change.
- R3: A reverse step, meaning the same order run backwards, decrements `position` by one with the same latency as R2.
- R4: If both phase lines change in the same clock cycle, `position` is left unchanged.
- R5: With `idxEn` high, a rising edge on `encIdx` loads `position` with 0, with the same latency as R2.
- R6: With `idxEn` low, rising edges on `encIdx` have no effect: `position` keeps counting steps and `lostCount` keeps its value.
- R7: At an index event, `lostCount` becomes 1 if the count held just before the clear is greater than +3 or less than -3.
- R8: At an index event, `lostCount` becomes 0 if the count held just before the clear lies in [-3, +3], the limits included.
- R9: Between index events, `lostCount` holds its value.
- R10: If a phase step and an index event are recognised in the same cycle, `position` becomes 0. The range check uses the count from before that step.
- R11: `position` is a 32-bit two's-complement value: one reverse step from 0 gives 32'hFFFFFFFF.
- R12: An index line held high clears the count only once, on its rising edge. Steps taken while it stays high are counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| encA | input | 1 | Encoder phase A, asynchronous |
| encB | input | 1 | Encoder phase B, asynchronous |
| encIdx | input | 1 | Encoder index pulse, asynchronous |
| idxEn | input | 1 | Lets index edges clear the count |
| position | output | 32 | Signed position count |
| lostCount | output | 1 | Set when an index event finds the count outside [-3, +3] |

## Verification
Each input change drives both results three rising edges later. Two of those edges go to the synchroniser. The third loads the count or the flag, with the step or index edge decoded from the synchronised history. The driver applies each stimulus on a falling edge and computes the expected count and flag from its own model of the phase order and the index rule. It queues that expectation tagged with a due cycle three edges ahead. The monitor compares the outputs on the falling edge of that cycle. Because every stimulus shares the same latency, stimuli are applied every cycle and the expectations leave the queue in order.

// File: rtl/qidx_pkg.sv
package qidx_pkg;
  typedef struct packed {
    logic inc;
    logic dec;
    logic zero;
  } ctrlStrobes_t;
endpackage

// File: rtl/qidxSync.sv
module qidxSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage;
      always_ff @(posedge clk) begin
        if (rst) stage <= 1'b0;
        else     stage <= din;
      end
      assign dout = stage;
    end else begin : g_chain
      logic [STAGES-1:0] shift;
      always_ff @(posedge clk) begin
        if (rst) shift <= '0;
        else     shift <= {shift[STAGES-2:0], din};
      end
      assign dout = shift[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/qidxControl.sv
module qidxControl
  import qidx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         encA,
  input  logic         encB,
  input  logic         encIdx,
  input  logic         idxEn,
  output ctrlStrobes_t strobes
);
  logic aSync, bSync, iSync;

  qidxSync #(.STAGES(SYNC_STAGES)) syncA_i (.clk(clk), .rst(rst), .din(encA),   .dout(aSync));
  qidxSync #(.STAGES(SYNC_STAGES)) syncB_i (.clk(clk), .rst(rst), .din(encB),   .dout(bSync));
  qidxSync #(.STAGES(SYNC_STAGES)) syncI_i (.clk(clk), .rst(rst), .din(encIdx), .dout(iSync));

  logic [1:0] abCur, abPrev;
  logic       idxPrev;
  logic       fwdStep, revStep, idxRise;

  assign abCur = {aSync, bSync};

  always_ff @(posedge clk) begin
    if (rst) begin
      abPrev  <= 2'b00;
      idxPrev <= 1'b0;
    end else begin
      abPrev  <= abCur;
      idxPrev <= iSync;
    end
  end

  // Gray transition table, pair is {A,B}; forward order 00,10,11,01
  always_comb begin
    fwdStep = 1'b0;
    revStep = 1'b0;
    case ({abPrev, abCur})
      4'b0010, 4'b1011, 4'b1101, 4'b0100: fwdStep = 1'b1;
      4'b0001, 4'b0111, 4'b1110, 4'b1000: revStep = 1'b1;
      default: ;
    endcase
  end

  assign idxRise      = iSync && !idxPrev;
  assign strobes.inc  = fwdStep;
  assign strobes.dec  = revStep;
  assign strobes.zero = idxRise && idxEn;

  // R4: a jump of both phases yields no step strobe
  a_r4_no_jump_step: assert property (@(posedge clk) disable iff (rst)
    ((abPrev ^ abCur) == 2'b11) |-> !(strobes.inc || strobes.dec));

  // R6: index is inert while disabled
  a_r6_disabled_idx: assert property (@(posedge clk) disable iff (rst)
    !idxEn |-> !strobes.zero);

  // R12: a held index cannot clear twice in a row
  a_r12_single_clear: assert property (@(posedge clk) disable iff (rst)
    strobes.zero |=> !strobes.zero);

  a_r2_one_direction: assert property (@(posedge clk) disable iff (rst)
    !(strobes.inc && strobes.dec));
endmodule

// File: rtl/qidxDatapath.sv
module qidxDatapath
  import qidx_pkg::*;
#(
  parameter int POS_W = 32,
  parameter int TOL   = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ctrlStrobes_t            strobes,
  output logic signed [POS_W-1:0] position,
  output logic                    lostCount
);
  localparam logic signed [POS_W-1:0] TOL_HI = POS_W'(TOL);
  localparam logic signed [POS_W-1:0] TOL_LO = -TOL_HI;

  logic outOfWindow;
  assign outOfWindow = (position > TOL_HI) || (position < TOL_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      position  <= '0;
      lostCount <= 1'b0;
    end else if (strobes.zero) begin
      position  <= '0;
      lostCount <= outOfWindow;  // checks the pre-clear value
    end else if (strobes.inc) begin
      position  <= position + 1'b1;
    end else if (strobes.dec) begin
      position  <= position - 1'b1;
    end
  end

  a_r2_inc_step: assert property (@(posedge clk) disable iff (rst)
    (strobes.inc && !strobes.zero) |=> position == $past(position) + 1'b1);

  a_r3_dec_step: assert property (@(posedge clk) disable iff (rst)
    (strobes.dec && !strobes.zero) |=> position == $past(position) - 1'b1);

  // R5 and R10: clear wins over any step
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (rst)
    strobes.zero |=> position == '0);

  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    (strobes.zero && (position > TOL_HI || position < TOL_LO)) |=> lostCount);

  a_r8_flag_clear: assert property (@(posedge clk) disable iff (rst)
    (strobes.zero && position <= TOL_HI && position >= TOL_LO) |=> !lostCount);

  a_r9_flag_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.zero |=> $stable(lostCount));
endmodule

// File: rtl/quadIndexCounter.sv
module quadIndexCounter
  import qidx_pkg::*;
#(
  parameter int POS_W       = 32,
  parameter int TOL         = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    encA,
  input  logic                    encB,
  input  logic                    encIdx,
  input  logic                    idxEn,
  output logic signed [POS_W-1:0] position,
  output logic                    lostCount
);
  ctrlStrobes_t strobes;

  qidxControl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rst(rst), .encA(encA), .encB(encB),
    .encIdx(encIdx), .idxEn(idxEn), .strobes(strobes)
  );

  qidxDatapath #(.POS_W(POS_W), .TOL(TOL)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes),
    .position(position), .lostCount(lostCount)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (position == '0 && !lostCount));
endmodule

// File: tb/quadIndexCounter_tb.sv
module quadIndexCounter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic encA = 1'b0, encB = 1'b0, encIdx = 1'b0, idxEn = 1'b0;
  logic signed [31:0] position;
  logic lostCount;

  always #5 clk = ~clk;

  quadIndexCounter dut_i (
    .clk(clk), .rst(rst), .encA(encA), .encB(encB), .encIdx(encIdx),
    .idxEn(idxEn), .position(position), .lostCount(lostCount)
  );

  typedef struct {
    int          due;
    logic [31:0] pos;
    logic        err;
    string       req;
  } item_t;

  item_t expQ[$];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int  mPos = 0;
  bit  mErr = 1'b0;
  int  phase = 0;   // 0:(0,0) 1:(1,0) 2:(1,1) 3:(0,1)

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [1:0] abOf(int ph);
    case (ph)
      0: abOf = 2'b00;
      1: abOf = 2'b10;
      2: abOf = 2'b11;
      default: abOf = 2'b01;
    endcase
  endfunction

  // Driver: apply one cycle of stimulus, model it, queue the expectation
  task automatic drive(int newPh, bit idx, bit en, bit jump, string req);
    bit rise;
    int diff;
    @(negedge clk);
    rise = idx && !encIdx && en;
    diff = (newPh - phase + 4) % 4;
    if (jump) begin
      encA = ~encA;
      encB = ~encB;
    end else begin
      {encA, encB} = abOf(newPh);
      phase = newPh;
    end
    encIdx = idx;
    idxEn  = en;
    if (rise) begin
      mErr = (mPos > 3) || (mPos < -3);
      mPos = 0;
    end else if (!jump && diff == 1) mPos = mPos + 1;
    else if (!jump && diff == 3) mPos = mPos - 1;
    expQ.push_back('{due: cyc + 3, pos: mPos, err: mErr, req: req});
  endtask

  task automatic fwd(int n, bit idx, bit en, string req);
    for (int k = 0; k < n; k++) drive((phase + 1) % 4, idx, en, 1'b0, req);
  endtask

  task automatic rev(int n, bit idx, bit en, string req);
    for (int k = 0; k < n; k++) drive((phase + 3) % 4, idx, en, 1'b0, req);
  endtask

  task automatic hold(int n, bit idx, bit en, string req);
    for (int k = 0; k < n; k++) drive(phase, idx, en, 1'b0, req);
  endtask

  // Monitor: compare due expectations away from the active edge
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].due <= cyc) begin
      item_t it;
      it = expQ.pop_front();
      checks++;
      if (position !== it.pos || lostCount !== it.err) begin
        failures++;
        $display("FAIL %s: position=%0d lostCount=%0b expected position=%0d lostCount=%0b",
                 it.req, position, lostCount, $signed(it.pos), it.err);
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (position !== 32'sd0 || lostCount !== 1'b0) begin
      failures++;
      $display("FAIL R1: position=%0d lostCount=%0b expected 0 0", position, lostCount);
    end
    rst = 1'b0;
    hold(2, 1'b0, 1'b0, "R1");
    fwd(10, 1'b0, 1'b0, "R2");            // reaches +10
    rev(13, 1'b0, 1'b1, "R3");            // reaches -3
    hold(3, 1'b0, 1'b1, "R3");
    hold(1, 1'b1, 1'b1, "R8");            // pre-clear -3 -> flag 0, count 0 (R5)
    hold(2, 1'b1, 1'b1, "R5");
    hold(2, 1'b0, 1'b1, "R5");
    rev(1, 1'b0, 1'b1, "R11");            // -1 = 32'hFFFFFFFF
    fwd(5, 1'b0, 1'b1, "R2");             // +4
    hold(2, 1'b0, 1'b1, "R2");
    hold(1, 1'b1, 1'b1, "R7");            // pre-clear +4 -> flag 1
    fwd(6, 1'b1, 1'b1, "R12");            // index held high, steps counted
    hold(2, 1'b1, 1'b1, "R9");
    hold(3, 1'b0, 1'b0, "R9");            // disable, index low
    hold(1, 1'b1, 1'b0, "R6");            // ignored rise
    fwd(2, 1'b1, 1'b0, "R6");             // +8, flag still 1
    hold(3, 1'b0, 1'b0, "R6");
    drive(phase, 1'b0, 1'b0, 1'b1, "R4"); // both phases flip: no count
    drive(phase, 1'b0, 1'b0, 1'b1, "R4"); // flip back: no count
    hold(3, 1'b0, 1'b1, "R4");
    hold(1, 1'b1, 1'b1, "R7");            // +8 -> flag 1, count 0
    hold(3, 1'b0, 1'b1, "R9");
    fwd(3, 1'b0, 1'b1, "R2");             // +3
    fwd(1, 1'b1, 1'b1, "R10");            // step with index: old +3 -> flag 0, count 0
    hold(3, 1'b0, 1'b1, "R8");
    rev(4, 1'b0, 1'b1, "R3");             // -4
    hold(1, 1'b1, 1'b1, "R7");            // -4 -> flag 1
    hold(2, 1'b0, 1'b1, "R9");
    rev(3, 1'b0, 1'b1, "R3");             // -3
    rev(1, 1'b1, 1'b1, "R10");            // step with index: old -3 -> flag 0
    hold(6, 1'b0, 1'b1, "R9");
    repeat (4) @(posedge clk);
    @(negedge clk);
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: pending=%0d expected 0", expQ.size());
    end
    summary();
  end
endmodule